// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block loads the per-frame descriptors that a display DMA needs before it starts moving pixels. At every frame-start pulse it visits each channel that is switched on and reads a 16-byte record from memory: four 32-bit words holding the link to the following record, the frame source address, a frame tag and a command word. The values it loads stay in per-channel storage for the pixel engine to use, and software can read them back.

Software sets each channel's link pointer through a write port. A separate one-shot branch register can send the next fetch to a different record. Every record address is checked against a memory window given by two inputs, and so is every source address that gets loaded. When a check fails the block reports a bus error tagged with the channel number. When the whole frame's fetch pass is over it sends a single done pulse.

Top module: `fdesc_fetch`

## Requirements
- R1: After reset every stored field of every channel reads zero, and `mem_req`, `done`, `ber_evt` and `bs_evt` are low.
- R2: A write with `wr_sel`=0 stores the data as the channel's link pointer with bits 3:0 forced to zero. A write with `wr_sel`=1 stores the data as the branch register with bits 3:2 forced to zero. In the branch register, bit 0 means branch pending, bit 1 means raise a branch event, and bits 31:4 give the record address.
- R3: On `frame_start` the enabled channels are visited in ascending channel order. Each one reads the words at ptr, ptr+4, ptr+8 and ptr+12 into link, source, tag and command, read codes 0, 1, 2 and 3; code 4 returns the branch register. The link is stored with bits 3:0 cleared, and the command word is stored unchanged (bits 20:2 length, bit 21 end-of-frame request, bit 22 start-of-frame request, bit 26 palette load).
- R4: During a pass, a disabled channel has its source cleared to zero. It issues no memory read, and its link, tag and command keep their values.
- R5: When branch pending is set, the record is read from branch bits 31:4 in place of the link pointer, and branch pending is then cleared. Bit 1 and the address bits are left as they were.
- R6: When a fetch uses the branch and bit 1 is set, `bs_evt[ch]` pulses for one cycle. A branch fetch with bit 1 clear raises no event.
- R7: A record is read only if ptr >= `win_lo` and ptr+16 <= `win_hi`. Otherwise no memory read is made and the channel's source stays zero.
- R8: An enabled channel that ends its visit with a source of zero, or a source below `win_lo` or above `win_hi`, raises a one-cycle `ber_evt` with `ber_ch` set to its number. A source equal to `win_hi` is accepted.
- R9: Only one memory read is outstanding at a time. `mem_req` stays high with a stable address until `mem_valid` arrives.
- R10: `done` pulses for one cycle after the last channel of a pass has been handled. A `frame_start` that arrives during a pass is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Starts a fetch pass |
| ch_enable | input | NCH | Per-channel enable |
| win_lo | input | AW | Lowest legal address |
| win_hi | input | AW | Highest legal address (inclusive bound) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = link pointer, 1 = branch register |
| wr_ch | input | CHW | Channel to write |
| wr_data | input | AW | Write data |
| rd_ch | input | CHW | Channel to read back |
| rd_field | input | 3 | Field to read: 0 link, 1 source, 2 tag, 3 command, 4 branch |
| rd_data | output | AW | Read-back value (combinational) |
| mem_addr | output | AW | Memory read address |
| mem_req | output | 1 | Memory read request |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| bs_evt | output | NCH | Branch event pulse per channel |
| ber_evt | output | 1 | Bus error pulse |
| ber_ch | output | CHW | Channel that raised the bus error |
| done | output | 1 | End-of-pass pulse |

## Verification
The bench runs a fetch pass for every one of the 128 enable patterns. After each pass it checks how many memory reads were made, the exact address order, and every channel's fields. A design that skipped the source clear, read disabled channels, or visited channels out of order would show a wrong address log or a stale source. The window is tested at both edges: a record that would end past `win_hi`, a record below `win_lo`, and a source exactly at `win_hi`. An off-by-one comparator would read a forbidden record or flag a legal source. The branch tests check that the redirect is taken only once, that the pending bit clears while the event-enable bit stays, and that the event fires only when enabled. A design that kept the branch pending would fetch the wrong tag on the following frame. A design that did not lock out re-triggering would run a second pass when `frame_start` is pulsed mid-pass.

// File: rtl/fdesc_pkg.sv
package fdesc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FETCH = 2'd2,
        ST_CHECK = 2'd3
    } fstate_e;

    localparam logic [2:0] FLD_LINK   = 3'd0;
    localparam logic [2:0] FLD_SRC    = 3'd1;
    localparam logic [2:0] FLD_TAG    = 3'd2;
    localparam logic [2:0] FLD_CMD    = 3'd3;
    localparam logic [2:0] FLD_BRANCH = 3'd4;

    localparam int REC_BYTES = 16;
endpackage

// File: rtl/fdesc_win.sv
module fdesc_win #(
    parameter int AW   = 32,
    parameter int SPAN = 16
) (
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] addr,
    output logic          ok
);
    logic [AW:0] top_w;

    always_comb begin
        top_w = {1'b0, addr} + (AW+1)'(SPAN);
        ok    = (addr >= lo) && (top_w <= {1'b0, hi});
    end
endmodule

// File: rtl/fdesc_fetch.sv
module fdesc_fetch
    import fdesc_pkg::*;
#(
    parameter int NCH  = 7,
    parameter int AW   = 32,
    parameter int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic [NCH-1:0]  ch_enable,
    input  logic [AW-1:0]   win_lo,
    input  logic [AW-1:0]   win_hi,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [CHW-1:0]  wr_ch,
    input  logic [AW-1:0]   wr_data,
    input  logic [CHW-1:0]  rd_ch,
    input  logic [2:0]      rd_field,
    output logic [AW-1:0]   rd_data,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_req,
    input  logic            mem_valid,
    input  logic [31:0]     mem_rdata,
    output logic [NCH-1:0]  bs_evt,
    output logic            ber_evt,
    output logic [CHW-1:0]  ber_ch,
    output logic            done
);
    localparam int CNTW = $clog2(NCH + 1);
    localparam logic [AW-1:0] LINK_MASK = ~AW'(15);
    localparam logic [AW-1:0] BR_WMASK  = ~AW'(12);

    typedef struct packed {
        fstate_e                  st;
        logic [CNTW-1:0]          ch;
        logic [1:0]               word;
        logic [AW-1:0]            ptr;
        logic [NCH-1:0][AW-1:0]   link;
        logic [NCH-1:0][AW-1:0]   src;
        logic [NCH-1:0][AW-1:0]   tag;
        logic [NCH-1:0][AW-1:0]   cmd;
        logic [NCH-1:0][AW-1:0]   br;
        logic [NCH-1:0]           bs;
        logic                     ber;
        logic [CHW-1:0]           berc;
        logic                     done;
    } state_t;

    state_t q, d;

    logic [CHW-1:0] ci;
    logic [AW-1:0]  sel_ptr;
    logic           rec_ok;
    logic           src_ok;

    assign ci      = (q.ch < CNTW'(NCH)) ? CHW'(q.ch) : '0;
    assign sel_ptr = q.br[ci][0] ? (q.br[ci] & LINK_MASK) : q.link[ci];

    fdesc_win #(.AW(AW), .SPAN(REC_BYTES)) u_rec_win (
        .lo(win_lo), .hi(win_hi), .addr(sel_ptr), .ok(rec_ok)
    );

    fdesc_win #(.AW(AW), .SPAN(0)) u_src_win (
        .lo(win_lo), .hi(win_hi), .addr(q.src[ci]), .ok(src_ok)
    );

    always_comb begin
        d      = q;
        d.bs   = '0;
        d.ber  = 1'b0;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    d.ch = '0;
                    d.st = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (q.ch == CNTW'(NCH)) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.src[ci] = '0;
                    if (!ch_enable[ci]) begin
                        d.ch = q.ch + 1'b1;
                    end else begin
                        if (q.br[ci][0]) begin
                            d.br[ci][0] = 1'b0;
                            d.bs[ci]    = q.br[ci][1];
                        end
                        d.ptr  = sel_ptr;
                        d.word = 2'd0;
                        d.st   = rec_ok ? ST_FETCH : ST_CHECK;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_valid) begin
                    case (q.word)
                        2'd0: d.link[ci] = AW'(mem_rdata) & LINK_MASK;
                        2'd1: d.src[ci]  = AW'(mem_rdata);
                        2'd2: d.tag[ci]  = AW'(mem_rdata);
                        default: begin
                            d.cmd[ci] = AW'(mem_rdata);
                            d.st      = ST_CHECK;
                        end
                    endcase
                    d.word = q.word + 2'd1;
                end
            end
            default: begin
                if (!src_ok || (q.src[ci] == '0)) begin
                    d.ber  = 1'b1;
                    d.berc = ci;
                end
                d.ch = q.ch + 1'b1;
                d.st = ST_SCAN;
            end
        endcase
        if (wr_en && (wr_ch < CHW'(NCH))) begin
            if (wr_sel) d.br[wr_ch]   = wr_data & BR_WMASK;
            else        d.link[wr_ch] = wr_data & LINK_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_ch < CHW'(NCH)) begin
            case (rd_field)
                FLD_LINK:   rd_data = q.link[rd_ch];
                FLD_SRC:    rd_data = q.src[rd_ch];
                FLD_TAG:    rd_data = q.tag[rd_ch];
                FLD_CMD:    rd_data = q.cmd[rd_ch];
                FLD_BRANCH: rd_data = q.br[rd_ch];
                default:    rd_data = '0;
            endcase
        end
    end

    assign mem_req  = (q.st == ST_FETCH);
    assign mem_addr = q.ptr + AW'({q.word, 2'b00});
    assign bs_evt   = q.bs;
    assign ber_evt  = q.ber;
    assign ber_ch   = q.berc;
    assign done     = q.done;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R9
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bs_evt)); // R6
    AST_BER_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ber_evt |-> (ber_ch < CHW'(NCH))); // R8
    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R10
endmodule

// File: tb/fdesc_fetch_test.sv
module fdesc_fetch_test;
    localparam int NCH = 7;
    localparam int AW  = 32;
    localparam int CHW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_start = 1'b0;
    logic [NCH-1:0]  ch_enable = '0;
    logic [AW-1:0]   win_lo = 32'h1000;
    logic [AW-1:0]   win_hi = 32'h1100;
    logic            wr_en = 1'b0;
    logic            wr_sel = 1'b0;
    logic [CHW-1:0]  wr_ch = '0;
    logic [AW-1:0]   wr_data = '0;
    logic [CHW-1:0]  rd_ch = '0;
    logic [2:0]      rd_field = '0;
    logic [AW-1:0]   rd_data;
    logic [AW-1:0]   mem_addr;
    logic            mem_req;
    logic            mem_valid = 1'b0;
    logic [31:0]     mem_rdata = '0;
    logic [NCH-1:0]  bs_evt;
    logic            ber_evt;
    logic [CHW-1:0]  ber_ch;
    logic            done;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [31:0] mem [64];
    logic [31:0] alog [256];
    int hs_cnt = 0;
    int done_cnt = 0;
    int ber_cnt = 0;
    int last_ber = -1;
    int bs_cnt [NCH];

    fdesc_fetch #(.NCH(NCH), .AW(AW), .CHW(CHW)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_enable(ch_enable),
        .win_lo(win_lo), .win_hi(win_hi), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_ch(wr_ch), .wr_data(wr_data), .rd_ch(rd_ch), .rd_field(rd_field),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_req(mem_req),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .bs_evt(bs_evt),
        .ber_evt(ber_evt), .ber_ch(ber_ch), .done(done)
    );

    always #5 clk = ~clk;

    // memory model: data one cycle after a request, one read in flight
    always @(posedge clk) begin
        mem_valid <= mem_req && !mem_valid;
        mem_rdata <= mem[mem_addr[7:2]];
    end

    initial for (int i = 0; i < NCH; i++) bs_cnt[i] = 0;

    always @(posedge clk) begin
        if (mem_req && mem_valid) begin
            alog[hs_cnt % 256] <= mem_addr;
            hs_cnt <= hs_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
        if (ber_evt) begin
            ber_cnt  <= ber_cnt + 1;
            last_ber <= int'(ber_ch);
        end
        for (int i = 0; i < NCH; i++) if (bs_evt[i]) bs_cnt[i] <= bs_cnt[i] + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int ch, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_ch = CHW'(ch); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int ch, input int fld, output logic [31:0] val);
        @(negedge clk);
        rd_ch = CHW'(ch); rd_field = 3'(fld);
        #1 val = rd_data;
    endtask

    task automatic run_frame(input logic [NCH-1:0] en, input bit extra);
        int d0;
        bit seen;
        d0 = done_cnt;
        seen = 0;
        @(negedge clk);
        ch_enable = en; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < 600 && !seen; i++) begin
            @(negedge clk);
            frame_start = extra && (i == 5 || i == 12);
            if (done_cnt != d0) seen = 1;
        end
        frame_start = 1'b0;
        check(seen, "R10 done timeout", 32'(done_cnt), 32'(d0 + 1));
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] src_of(input int c);
        return 32'h1080 + 32'(c * 4);
    endfunction

    initial begin
        logic [31:0] v;
        int h0, b0, e0, nerr, pc, k;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        for (int c = 0; c < NCH; c++) begin
            mem[c*4 + 0] = 32'h1000 + 32'(c * 16);
            mem[c*4 + 1] = src_of(c);
            mem[c*4 + 2] = 32'hA0 + 32'(c);
            mem[c*4 + 3] = 32'h0060_0000 | 32'(c << 2);
        end
        mem[28] = 32'h1030; mem[29] = 32'h10C0; mem[30] = 32'h77; mem[31] = 32'h0400_0010;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        nerr = 0;
        for (int c = 0; c < NCH; c++)
            for (int f = 0; f < 5; f++) begin
                rd(c, f, v);
                if (v !== 32'h0) nerr++;
            end
        check(nerr == 0, "R1 fields zero", 32'(nerr), 0);
        check({mem_req, done, ber_evt, bs_evt} == '0, "R1 outputs low",
              32'({mem_req, done, ber_evt, bs_evt}), 0);

        // R2 write masks
        wr(0, 0, 32'h1007);
        rd(0, 0, v); check(v == 32'h1000, "R2 link mask", v, 32'h1000);
        wr(1, 1, 32'hFFFF_FFFF);
        rd(1, 4, v); check(v == 32'hFFFF_FFF3, "R2 branch mask", v, 32'hFFFF_FFF3);
        wr(1, 1, 32'h0);
        for (int c = 0; c < NCH; c++) wr(0, c, 32'h1000 + 32'(c * 16));

        // R3 R4 R9 sweep over all enable patterns, descending
        for (int p = 127; p >= 0; p--) begin
            h0 = hs_cnt; b0 = ber_cnt;
            run_frame(7'(p), 0);
            pc = $countones(7'(p));
            check(hs_cnt - h0 == 4 * pc, "R4 read count", 32'(hs_cnt - h0), 32'(4 * pc));
            nerr = 0; k = h0;
            for (int c = 0; c < NCH; c++)
                if (p[c])
                    for (int w = 0; w < 4; w++) begin
                        if (alog[k % 256] != 32'h1000 + 32'(c * 16 + w * 4)) nerr++;
                        k++;
                    end
            check(nerr == 0, "R3 address order", 32'(nerr), 0);
            nerr = 0;
            for (int c = 0; c < NCH; c++) begin
                rd(c, 1, v); if (v != (p[c] ? src_of(c) : 32'h0)) nerr++;
                rd(c, 2, v); if (v != 32'hA0 + 32'(c)) nerr++;
                rd(c, 3, v); if (v != (32'h0060_0000 | 32'(c << 2))) nerr++;
                rd(c, 0, v); if (v != 32'h1000 + 32'(c * 16)) nerr++;
            end
            check(nerr == 0, "R3 R4 fields", 32'(nerr), 0);
            check(ber_cnt == b0, "R8 no false error", 32'(ber_cnt - b0), 0);
        end

        // R5 R6 branch with event
        wr(1, 3, 32'h1073);
        h0 = hs_cnt; e0 = bs_cnt[3];
        run_frame(7'h08, 0);
        check(alog[h0 % 256] == 32'h1070, "R5 branch address", alog[h0 % 256], 32'h1070);
        rd(3, 2, v); check(v == 32'h77, "R5 branch tag", v, 32'h77);
        rd(3, 1, v); check(v == 32'h10C0, "R5 branch source", v, 32'h10C0);
        rd(3, 0, v); check(v == 32'h1030, "R5 new link", v, 32'h1030);
        rd(3, 3, v); check(v == 32'h0400_0010, "R3 command verbatim", v, 32'h0400_0010);
        rd(3, 4, v); check(v == 32'h1072, "R5 pending cleared", v, 32'h1072);
        check(bs_cnt[3] == e0 + 1, "R6 event raised", 32'(bs_cnt[3]), 32'(e0 + 1));
        run_frame(7'h08, 0);
        rd(3, 2, v); check(v == 32'hA3, "R5 one-shot", v, 32'hA3);
        check(bs_cnt[3] == e0 + 1, "R6 no repeat event", 32'(bs_cnt[3]), 32'(e0 + 1));
        wr(1, 3, 32'h1071);
        run_frame(7'h08, 0);
        rd(3, 2, v); check(v == 32'h77, "R5 branch no event", v, 32'h77);
        check(bs_cnt[3] == e0 + 1, "R6 event disabled", 32'(bs_cnt[3]), 32'(e0 + 1));
        rd(3, 4, v); check(v == 32'h1070, "R5 pending cleared 2", v, 32'h1070);

        // R7 R8 window edges on channel 5
        wr(0, 5, 32'h1100);
        h0 = hs_cnt; b0 = ber_cnt;
        run_frame(7'h20, 0);
        check(hs_cnt == h0, "R7 past top rejected", 32'(hs_cnt - h0), 0);
        rd(5, 1, v); check(v == 32'h0, "R7 source zero", v, 0);
        check(ber_cnt == b0 + 1 && last_ber == 5, "R8 error tagged", 32'(last_ber), 5);
        wr(0, 5, 32'h0FF0);
        h0 = hs_cnt; b0 = ber_cnt;
        run_frame(7'h20, 0);
        check(hs_cnt == h0, "R7 below bottom rejected", 32'(hs_cnt - h0), 0);
        check(ber_cnt == b0 + 1, "R8 error below", 32'(ber_cnt - b0), 1);
        mem[60] = 32'h10F0; mem[61] = 32'h1100; mem[62] = 32'h55; mem[63] = 32'h0;
        wr(0, 5, 32'h10F0);
        h0 = hs_cnt; b0 = ber_cnt;
        run_frame(7'h20, 0);
        check(hs_cnt - h0 == 4, "R7 last record accepted", 32'(hs_cnt - h0), 4);
        rd(5, 2, v); check(v == 32'h55, "R7 edge tag", v, 32'h55);
        check(ber_cnt == b0, "R8 source at top ok", 32'(ber_cnt - b0), 0);
        mem[61] = 32'h1104; b0 = ber_cnt;
        run_frame(7'h20, 0);
        check(ber_cnt == b0 + 1 && last_ber == 5, "R8 source above top", 32'(ber_cnt - b0), 1);
        mem[61] = 32'h0; b0 = ber_cnt;
        run_frame(7'h20, 0);
        check(ber_cnt == b0 + 1, "R8 source zero", 32'(ber_cnt - b0), 1);
        mem[61] = 32'h0FFC; b0 = ber_cnt;
        run_frame(7'h20, 0);
        check(ber_cnt == b0 + 1, "R8 source below", 32'(ber_cnt - b0), 1);
        wr(0, 5, 32'h1050);

        // R10 retrigger during a pass is ignored
        h0 = hs_cnt; b0 = done_cnt;
        run_frame(7'h7F, 1);
        repeat (200) @(negedge clk);
        check(done_cnt == b0 + 1, "R10 single done", 32'(done_cnt - b0), 1);
        check(hs_cnt - h0 == 28, "R10 single pass", 32'(hs_cnt - h0), 28);
        check(!mem_req, "R10 idle after pass", 32'(mem_req), 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule